// File: doc/BRIEF.md
# Interrupt and Reset Sequencer

This block is the part of an 8-bit controller core that handles reset and the entry into and exit from interrupt service routines. It owns the stack pointer and the interrupt mask bit. The core signals the instruction boundary and the decoded software-interrupt, return and mask-clear instructions. The block then drives the memory bus on its own. It writes the register state to the stack, reads a two-byte vector from the top of the address space, and pulses load strobes that tell the core which of its registers to overwrite and with what value.

On reset the block presents the start-up values for the stack pointer, the port direction registers, the timer counter, the timer control register and the prescaler. It then fetches the reset vector. An interrupt entry takes five write cycles, two vector-read cycles and then the return to idle. A return takes five read cycles. The `busy` output tells the core to stall while a sequence runs.

Top module: `irq_seq`

## Requirements
- R1: While `rst_n` is low, `init_ld` is 1, `ddr_val`=0x00, `tdr_val`=0xFF, `tcr_val`=0x7F, `psc_val`=0x7F, `sp`=0x7F, `i_mask`=1 and `busy`=1.
- R2: In the first clock after reset is released, the block reads address 0xFFE (high byte). In the next cycle it reads 0xFFF (low byte) and pulses `load_pc` with `load_data`={byte@0xFFE, byte@0xFFF}. In the cycle after that `busy` is 0.
- R3: The vector pairs are: timer at 0xFF8/0xFF9, external at 0xFFA/0xFFB, software at 0xFFC/0xFFD. The even address holds the high byte. The new PC appears on `load_data` with `load_pc` in the second read cycle.
- R4: An entry writes one byte per cycle for five consecutive cycles, in this order: PC[7:0], PC[15:8], X, A, CC. The CC byte is `cc_in` with bit 3 replaced by the mask value from before the entry. The first write goes to address `sp`.
- R5: The stack pointer decrements after each written byte and increments before each read byte. It wraps modulo 2^SPW.
- R6: `i_mask` is 1 once the last byte has been stacked and the first vector read begins.
- R7: A `swi_strobe` in an idle cycle starts an entry whatever the value of `i_mask`.
- R8: A `rti_strobe` in an idle cycle reads five bytes from sp+1 upward, in this order: CC (`load_cc`), A (`load_a`), X (`load_x`), PC high (no strobe), PC low (`load_pc` with the 16-bit PC). `i_mask` takes bit 3 of the pulled CC byte.
- R9: Hardware requests are taken only in an idle cycle with `boundary`=1 and `i_mask`=0. Otherwise `busy` stays 0.
- R10: A rising edge of `ext_req` is latched as pending, even while busy. The pending flag is cleared only by taking the external interrupt or by reset. At a boundary where both are eligible, the pending external request is served before `tmr_req` (a level).
- R11: When starts coincide in an idle cycle, the priority is software interrupt, then return, then external, then timer. Strobes that arrive while busy have no effect.
- R12: `cli_strobe` in an idle cycle where no sequence starts clears `i_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boundary | input | 1 | Core is between instructions |
| swi_strobe | input | 1 | Software-interrupt instruction decoded |
| rti_strobe | input | 1 | Return-from-interrupt decoded |
| cli_strobe | input | 1 | Mask-clear instruction decoded |
| ext_req | input | 1 | External interrupt line (edge sensitive) |
| tmr_req | input | 1 | Timer interrupt request (level) |
| pc_in | input | 16 | Core program counter to be stacked |
| x_in | input | 8 | Index register to be stacked |
| a_in | input | 8 | Accumulator to be stacked |
| cc_in | input | 8 | Condition codes to be stacked (bit 3 replaced) |
| mem_rdata | input | 8 | Read data, valid in the read cycle |
| mem_addr | output | AW | Bus address |
| mem_rd | output | 1 | Read cycle |
| mem_wr | output | 1 | Write cycle |
| mem_wdata | output | 8 | Write data |
| load_pc | output | 1 | Core loads PC from load_data |
| load_x | output | 1 | Core loads X from load_data[7:0] |
| load_a | output | 1 | Core loads A from load_data[7:0] |
| load_cc | output | 1 | Core loads CC from load_data[7:0] |
| load_data | output | 16 | Value for the load strobes |
| init_ld | output | 1 | Start-up load of peripheral registers |
| ddr_val | output | 8 | Direction register start value |
| tdr_val | output | 8 | Timer counter start value |
| tcr_val | output | 8 | Timer control start value |
| psc_val | output | 8 | Prescaler start value |
| i_mask | output | 1 | Interrupt mask bit |
| sp | output | SPW | Stack pointer |
| busy | output | 1 | A sequence is running, core stalls |

## Verification
Several things can land on the same idle cycle: a decoded software interrupt or return, an instruction boundary with the timer request high, and a latched external edge. The bench raises these together, in directed cases and at random, and it judges the result by which bus sequence follows. A write burst whose vector read hits 0xFFC means the software interrupt won. A read burst means the return won. A vector read at 0xFFA or 0xFF8 shows which hardware source won. A second overlap is an external edge that arrives in the middle of a stacking burst. The bench confirms that this edge is served at a later boundary after the mask is cleared.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int AW = 12,
  parameter int SPW = 7,
  parameter logic [SPW-1:0] SP_RST = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           boundary,
  input  logic           swi_strobe,
  input  logic           rti_strobe,
  input  logic           cli_strobe,
  input  logic           ext_req,
  input  logic           tmr_req,
  input  logic [15:0]    pc_in,
  input  logic [7:0]     x_in,
  input  logic [7:0]     a_in,
  input  logic [7:0]     cc_in,
  input  logic [7:0]     mem_rdata,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [7:0]     mem_wdata,
  output logic           load_pc,
  output logic           load_x,
  output logic           load_a,
  output logic           load_cc,
  output logic [15:0]    load_data,
  output logic           init_ld,
  output logic [7:0]     ddr_val,
  output logic [7:0]     tdr_val,
  output logic [7:0]     tcr_val,
  output logic [7:0]     psc_val,
  output logic           i_mask,
  output logic [SPW-1:0] sp,
  output logic           busy
);
  localparam int IBIT = 3;
  localparam logic [7:0] IMSK = 8'(1 << IBIT);
  localparam logic [AW-1:0] VBASE = {{(AW-3){1'b1}}, 3'b000};

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_PUSH, S_VECH, S_VECL, S_PULL} st_t;

  st_t            st;
  logic [2:0]     step;
  logic [SPW-1:0] sp_q, sp_up;
  logic           i_q, pend, ext_q;
  logic [1:0]     vsel;
  logic [7:0]     hold;
  logic [AW-1:0]  vaddr;
  logic           idle, hw_ok, go_swi, go_rti, go_ext, go_tmr, go_ent;

  assign idle   = (st == S_IDLE);
  assign hw_ok  = idle & boundary & ~i_q & ~swi_strobe & ~rti_strobe;
  assign go_swi = idle & swi_strobe;
  assign go_rti = idle & ~swi_strobe & rti_strobe;
  assign go_ext = hw_ok & pend;
  assign go_tmr = hw_ok & ~pend & tmr_req;
  assign go_ent = go_swi | go_ext | go_tmr;

  assign sp_up = sp_q + SPW'(1);
  assign vaddr = VBASE | {{(AW-3){1'b0}}, vsel, 1'b0};

  always_comb begin
    case (st)
      S_PUSH:  mem_addr = {{(AW-SPW){1'b0}}, sp_q};
      S_PULL:  mem_addr = {{(AW-SPW){1'b0}}, sp_up};
      S_VECH:  mem_addr = vaddr;
      S_VECL:  mem_addr = vaddr | AW'(1);
      default: mem_addr = '0;
    endcase
    case (step)
      3'd0:    mem_wdata = pc_in[7:0];
      3'd1:    mem_wdata = pc_in[15:8];
      3'd2:    mem_wdata = x_in;
      3'd3:    mem_wdata = a_in;
      default: mem_wdata = (cc_in & ~IMSK) | (i_q ? IMSK : 8'h00);
    endcase
  end

  assign mem_wr    = (st == S_PUSH);
  assign mem_rd    = (st == S_VECH) | (st == S_VECL) | (st == S_PULL);
  assign load_cc   = (st == S_PULL) & (step == 3'd0);
  assign load_a    = (st == S_PULL) & (step == 3'd1);
  assign load_x    = (st == S_PULL) & (step == 3'd2);
  assign load_pc   = (st == S_VECL) | ((st == S_PULL) & (step == 3'd4));
  assign load_data = load_pc ? {hold, mem_rdata} : {8'h00, mem_rdata};

  assign init_ld = (st == S_INIT);
  assign ddr_val = 8'h00;
  assign tdr_val = 8'hFF;
  assign tcr_val = 8'h7F;
  assign psc_val = 8'h7F;
  assign i_mask  = i_q;
  assign sp      = sp_q;
  assign busy    = ~idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_INIT;
      step  <= 3'd0;
      sp_q  <= SP_RST;
      i_q   <= 1'b1;
      pend  <= 1'b0;
      ext_q <= 1'b0;
      vsel  <= 2'd3;
      hold  <= 8'h00;
    end else begin
      ext_q <= ext_req;
      pend  <= (pend & ~go_ext) | (ext_req & ~ext_q);
      case (st)
        S_INIT: st <= S_VECH;
        S_IDLE: begin
          step <= 3'd0;
          if (go_ent) begin
            st   <= S_PUSH;
            vsel <= go_swi ? 2'd2 : (go_ext ? 2'd1 : 2'd0);
          end else if (go_rti) begin
            st <= S_PULL;
          end else if (cli_strobe) begin
            i_q <= 1'b0;
          end
        end
        S_PUSH: begin
          sp_q <= sp_q - SPW'(1);
          if (step == 3'd4) begin
            i_q <= 1'b1;
            st  <= S_VECH;
          end else begin
            step <= step + 3'd1;
          end
        end
        S_VECH: begin
          hold <= mem_rdata;
          st   <= S_VECL;
        end
        S_VECL: st <= S_IDLE;
        S_PULL: begin
          sp_q <= sp_up;
          if (step == 3'd0) i_q <= mem_rdata[IBIT];
          if (step == 3'd3) hold <= mem_rdata;
          if (step == 3'd4) st <= S_IDLE;
          else step <= step + 3'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module irq_seq_chk #(
  parameter int AW = 12,
  parameter int SPW = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           boundary,
  input logic           swi_strobe,
  input logic           rti_strobe,
  input logic           busy,
  input logic           i_mask,
  input logic [SPW-1:0] sp,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [AW-1:0]  mem_addr,
  input logic           load_pc,
  input logic           load_x,
  input logic           load_a,
  input logic           load_cc,
  input logic           init_ld
);
  localparam logic [AW-1:0] RST_HI = {{(AW-3){1'b1}}, 3'b110};

  a_r2_init_then_vector: assert property (@(posedge clk) disable iff (!rst_n)
    init_ld |=> (mem_rd && mem_addr == RST_HI));

  a_r5_push_decrements: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> (sp == $past(sp) - SPW'(1)));

  a_r5_pull_increments: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cc || load_a || load_x) |=> (sp == $past(sp) + SPW'(1)));

  a_r6_mask_after_stack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wr) |-> (i_mask && mem_rd));

  a_r7_swi_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && swi_strobe) |=> mem_wr);

  a_r9_masked_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && boundary && i_mask && !swi_strobe && !rti_strobe) |=> !busy);

  a_r4_one_bus_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr) && $onehot0({load_pc, load_x, load_a, load_cc}));
endmodule

bind irq_seq irq_seq_chk #(.AW(AW), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .swi_strobe(swi_strobe),
  .rti_strobe(rti_strobe), .busy(busy), .i_mask(i_mask), .sp(sp),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr), .load_pc(load_pc),
  .load_x(load_x), .load_a(load_a), .load_cc(load_cc), .init_ld(init_ld)
);

// File: tb/irq_seq_tb.sv
module irq_seq_tb;
  localparam int AW = 12;
  localparam int SPW = 7;
  localparam logic [AW-1:0] VBASE = 12'hFF8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, swi_strobe = 0, rti_strobe = 0, cli_strobe = 0;
  logic ext_req = 0, tmr_req = 0;
  logic [15:0] pc_in = 0;
  logic [7:0] x_in = 0, a_in = 0, cc_in = 0;
  logic [7:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [7:0] mem_wdata;
  logic load_pc, load_x, load_a, load_cc;
  logic [15:0] load_data;
  logic init_ld;
  logic [7:0] ddr_val, tdr_val, tcr_val, psc_val;
  logic i_mask;
  logic [SPW-1:0] sp;
  logic busy;

  always #4 clk = ~clk;

  irq_seq #(.AW(AW), .SPW(SPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .swi_strobe(swi_strobe),
    .rti_strobe(rti_strobe), .cli_strobe(cli_strobe), .ext_req(ext_req),
    .tmr_req(tmr_req), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .load_pc(load_pc), .load_x(load_x), .load_a(load_a),
    .load_cc(load_cc), .load_data(load_data), .init_ld(init_ld),
    .ddr_val(ddr_val), .tdr_val(tdr_val), .tcr_val(tcr_val), .psc_val(psc_val),
    .i_mask(i_mask), .sp(sp), .busy(busy)
  );

  logic [7:0] stk [128];
  logic [7:0] estk [128];
  logic [7:0] vec [8];
  assign mem_rdata = (mem_addr >= VBASE) ? vec[mem_addr[2:0]] : stk[mem_addr[6:0]];
  always @(posedge clk) if (mem_wr) stk[mem_addr[6:0]] <= mem_wdata;

  logic [6:0] m_sp;
  logic m_i, m_pend;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R1 init strobe", 32'(init_ld), 1);
      chk("R1 ddr value", 32'(ddr_val), 32'h00);
      chk("R1 timer value", 32'(tdr_val), 32'hFF);
      chk("R1 control value", 32'(tcr_val), 32'h7F);
      chk("R1 prescaler value", 32'(psc_val), 32'h7F);
      chk("R1 sp", 32'(sp), 32'h7F);
      chk("R1 mask", 32'(i_mask), 1);
      chk("R1 busy", 32'(busy), 1);
    end
    rst_n = 1;
    m_sp = 7'h7F; m_i = 1; m_pend = 0;
    tick();
    chk("R2 reset vector high read", 32'({mem_rd, mem_addr}), 32'({1'b1, 12'hFFE}));
    tick();
    chk("R2 reset vector low read", 32'({mem_rd, mem_addr}), 32'({1'b1, 12'hFFF}));
    chk("R2 reset pc load", 32'({load_pc, load_data}), 32'({1'b1, vec[6], vec[7]}));
    tick();
    chk("R2 idle after reset", 32'(busy), 0);
  endtask

  task automatic entry(input int src, input bit bump, input string tag);
    logic [7:0] b [5];
    b[0] = pc_in[7:0]; b[1] = pc_in[15:8]; b[2] = x_in; b[3] = a_in;
    b[4] = {cc_in[7:4], m_i, cc_in[2:0]};
    tick();
    swi_strobe = 0; rti_strobe = 0; boundary = 0;
    if (src == 1) m_pend = 0;
    for (int k = 0; k < 5; k++) begin
      chk("R4 write cycle", 32'({mem_wr, mem_rd}), 32'b10);
      chk("R4 push address", 32'(mem_addr), 32'(m_sp));
      chk("R4 push byte", 32'(mem_wdata), 32'(b[k]));
      chk("R5 sp during push", 32'(sp), 32'(m_sp));
      estk[m_sp] = b[k];
      m_sp = m_sp - 7'd1;
      if (bump && k == 1) begin ext_req = 1; m_pend = 1; end
      if (bump && k == 2) ext_req = 0;
      tick();
    end
    chk("R6 mask set before vector", 32'(i_mask), 1);
    chk("R5 sp after push", 32'(sp), 32'(m_sp));
    chk({tag, " vector high read"}, 32'({mem_rd, mem_addr}), 32'({1'b1, VBASE + 12'(2*src)}));
    tick();
    chk({tag, " vector low read"}, 32'({mem_rd, mem_addr}), 32'({1'b1, VBASE + 12'(2*src+1)}));
    chk("R3 vector pc load", 32'({load_pc, load_data}), 32'({1'b1, vec[2*src], vec[2*src+1]}));
    m_i = 1;
    tick();
    chk("R4 idle after entry", 32'(busy), 0);
  endtask

  task automatic pull(input string tag);
    logic [7:0] hi;
    hi = 0;
    tick();
    swi_strobe = 0; rti_strobe = 0; boundary = 0;
    for (int k = 0; k < 5; k++) begin
      logic [6:0] nx;
      logic [7:0] by;
      nx = m_sp + 7'd1;
      by = estk[nx];
      chk({tag, " pull read"}, 32'({mem_wr, mem_rd, mem_addr}), 32'({2'b01, 5'b0, nx}));
      case (k)
        0: begin
          chk("R8 cc load", 32'({load_cc, load_a, load_x, load_pc, load_data}), 32'({4'b1000, 8'h00, by}));
          m_i = by[3];
        end
        1: chk("R8 a load", 32'({load_cc, load_a, load_x, load_pc, load_data}), 32'({4'b0100, 8'h00, by}));
        2: chk("R8 x load", 32'({load_cc, load_a, load_x, load_pc, load_data}), 32'({4'b0010, 8'h00, by}));
        3: begin
          chk("R8 pc high no strobe", 32'({load_cc, load_a, load_x, load_pc}), 0);
          hi = by;
        end
        default: chk("R8 pc load", 32'({load_cc, load_a, load_x, load_pc, load_data}), 32'({4'b0001, hi, by}));
      endcase
      m_sp = nx;
      tick();
    end
    chk("R8 idle after return", 32'(busy), 0);
    chk("R8 mask restored", 32'(i_mask), 32'(m_i));
    chk("R5 sp after pull", 32'(sp), 32'(m_sp));
  endtask

  task automatic op_boundary(input bit t, input string tag);
    boundary = 1; tmr_req = t;
    if (!m_i && m_pend) entry(1, 0, tag);
    else if (!m_i && t) entry(0, 0, tag);
    else begin
      tick();
      boundary = 0;
      chk({tag, " request held off"}, 32'(busy), 0);
    end
  endtask

  task automatic op_ext();
    ext_req = 1; m_pend = 1;
    tick();
    ext_req = 0;
    chk("R10 edge alone starts nothing", 32'(busy), 0);
    tick();
  endtask

  task automatic op_cli();
    cli_strobe = 1;
    tick();
    cli_strobe = 0;
    m_i = 0;
    chk("R12 mask cleared", 32'(i_mask), 0);
  endtask

  task automatic rnd_regs();
    pc_in = 16'($urandom); x_in = 8'($urandom); a_in = 8'($urandom); cc_in = 8'($urandom);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd97531));
    for (int i = 0; i < 128; i++) begin stk[i] = 0; estk[i] = 0; end
    for (int i = 0; i < 8; i++) vec[i] = 8'($urandom);
    m_sp = 7'h7F; m_i = 1; m_pend = 0;
    do_reset();

    rnd_regs(); swi_strobe = 1; entry(2, 0, "R7 swi with mask set");
    op_boundary(1, "R9");
    op_cli();
    op_ext();
    rnd_regs(); op_boundary(1, "R10 external before timer");
    rti_strobe = 1; pull("R8");
    chk("R8 mask cleared by pulled cc", 32'(i_mask), 0);
    rnd_regs(); op_boundary(1, "R3 timer vector");
    rti_strobe = 1; pull("R8");
    rnd_regs(); swi_strobe = 1; boundary = 1; tmr_req = 1;
    entry(2, 0, "R11 swi beats timer");
    rti_strobe = 1; boundary = 1; tmr_req = 1; pull("R11 return beats timer");
    rnd_regs(); swi_strobe = 1; entry(2, 1, "R11 swi with edge while busy");
    op_cli();
    rnd_regs(); op_boundary(1, "R10 edge during stacking served");

    for (int i = 0; i < 27; i++) begin rnd_regs(); swi_strobe = 1; entry(2, 0, "R5 wrap"); end
    for (int i = 0; i < 27; i++) begin rti_strobe = 1; pull("R5 wrap"); end

    for (int i = 0; i < 300; i++) begin
      int op;
      rnd_regs();
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin
          swi_strobe = 1;
          if ($urandom_range(0, 1) == 1) begin boundary = 1; tmr_req = 1'($urandom); end
          entry(2, 1'($urandom), "R11 swi");
        end
        1: begin
          rti_strobe = 1;
          if ($urandom_range(0, 1) == 1) begin boundary = 1; tmr_req = 1'($urandom); end
          pull("R11 return");
        end
        2: op_boundary(1'($urandom), "R9 R10 boundary");
        3: op_ext();
        4: op_cli();
        default: begin
          tick();
          chk("R9 idle stays idle", 32'(busy), 0);
        end
      endcase
    end

    op_ext();
    swi_strobe = 1;
    tick();
    swi_strobe = 0;
    tick();
    do_reset();
    op_cli();
    op_boundary(0, "R10 reset clears pending");

    finish_run();
  end
endmodule